// File: doc/BRIEF.md
# Crystal-Locked System Clock Enable Generator

This block turns one master video clock into the full set of slower system timing signals: a pixel-rate clock, a processor/system clock, a colour clock and a slow peripheral clock with a 40/60 duty cycle. Every output is produced by integer division of the master count, so all of them keep a fixed phase relationship to one another and to the master. Each divided clock comes out both as a level and as a one-master-cycle enable pulse on its rising edge, so that synchronous logic on the master clock can use it without a second clock domain.

The master count can advance on every cycle of the internal clock, or it can follow an external timing source. The external source is modelled as a per-cycle tick input, and an active-low select chooses it. A change of source is accepted only when a colour-clock period completes, so no divider ever sees a shortened period. A quadrature colour-clock phase signal, lagging the colour clock by a quarter period, is exported for logic that needs a second phase.

Top module: `vclk_divider`

## Requirements
- R1: While reset is asserted, and in the cycle it is released, the four clock levels (dot_clk, cpu_clk, cck_clk, e_clk) are high, cck_ph is low and all four enable pulses are low.
- R2: With T the number of master ticks since reset, dot_clk is high when T is even, and dot_en is high for one cycle in each cycle whose tick makes T even. That is one pulse every 2 ticks.
- R3: cpu_clk is high when T mod 4 is 0 or 1, and cpu_en pulses when a tick makes T mod 4 equal 0. That is one pulse every 4 ticks, at a rising edge of cpu_clk.
- R4: cck_clk is high when T mod 8 is below 4, and cck_en pulses when a tick makes T mod 8 equal 0. Every cck_en coincides with a cpu_en and a dot_en.
- R5: cck_ph is high exactly when T mod 8 is 2, 3, 4 or 5, which is a quarter colour period behind cck_clk.
- R6: e_clk is high when T mod 40 is below 16 and low otherwise: 4 CPU periods high and 6 low. e_en pulses when a tick makes T mod 40 equal 0, always together with a cpu_en, and e_clk rises only on such a pulse.
- R7: While the external source is in use, the master count advances only in cycles where ext_tick is high. In other cycles no level changes and no enable pulse fires.
- R8: A change of ext_clk_en_n (low = external source) is taken up only on the tick that completes a colour period (T mod 8 going from 7 to 0). Ticks of the old source run until then.
- R9: Every enable pulse is exactly one master cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_clk_en_n | input | 1 | Low selects the external tick as the master count source |
| ext_tick | input | 1 | External source tick, one per external master period |
| dot_clk | output | 1 | Master divided by 2, level |
| dot_en | output | 1 | One-cycle pulse on each dot_clk rising edge |
| cpu_clk | output | 1 | Master divided by 4, level |
| cpu_en | output | 1 | One-cycle pulse on each cpu_clk rising edge |
| cck_clk | output | 1 | Master divided by 8, colour clock level |
| cck_en | output | 1 | One-cycle pulse on each cck_clk rising edge |
| cck_ph | output | 1 | Colour clock delayed by a quarter period |
| e_clk | output | 1 | Master divided by 40, 16 high / 24 low |
| e_en | output | 1 | One-cycle pulse on each e_clk rising edge |

## Verification
Every output is registered once after the tick that causes it. The source select is registered too, so it applies from the tick after the colour boundary. Each result is therefore due at the first clock edge that counts the tick. The bench drives inputs at the falling edge, updates its own tick count T and source model right after the rising edge, and compares all outputs at the next falling edge, half a cycle after they settle. Stall and switch cases are also checked against counts worked out by hand: the number of dot_clk toggles before a stall, and levels that stay unchanged across cycles without a tick.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

    // Number of binary divide stages: dot (/2), cpu (/4), colour (/8)
    localparam int unsigned DEF_STAGES  = 3;
    // Slow peripheral clock: ratio to the cpu clock and its high time
    localparam int unsigned DEF_E_RATIO = 10;
    localparam int unsigned DEF_E_HIGH  = 4;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

endpackage

// File: rtl/vclk_src_sel.sv
module vclk_src_sel
    import vclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_sel_n,
    input  logic ext_tick,
    input  logic period_last,
    output logic mtick
);

    typedef struct packed {
        src_e src;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        mtick = (sel_q.src == SRC_EXT) ? ext_tick : 1'b1;
        // only the tick that closes a colour period may change the source
        if (mtick && period_last) begin
            sel_d.src = ext_sel_n ? SRC_INT : SRC_EXT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '{src: SRC_INT};
        end else begin
            sel_q <= sel_d;
        end
    end

endmodule

// File: rtl/vclk_prescale.sv
module vclk_prescale #(
    parameter int unsigned STAGES   = 3,
    parameter int unsigned STEP_IDX = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [STAGES-1:0] lvl,
    output logic [STAGES-1:0] en,
    output logic              step,
    output logic              last,
    output logic              ph
);

    localparam int unsigned TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] cnt;
        logic [STAGES-1:0] en;
    } pre_t;

    pre_t              pre_d, pre_q;
    logic [STAGES-1:0] cnt_next;
    logic [STAGES-1:0] rise_next;

    // a stage rises when the tick clears all of its lower count bits
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        assign rise_next[i] = tick && (cnt_next[i:0] == '0);
    end

    always_comb begin
        pre_d    = pre_q;
        cnt_next = tick ? pre_q.cnt + 1'b1 : pre_q.cnt;
        pre_d.cnt = cnt_next;
        pre_d.en  = rise_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign lvl  = ~pre_q.cnt;
    assign en   = pre_q.en;
    assign step = rise_next[STEP_IDX];
    assign last = &pre_q.cnt;
    assign ph   = pre_q.cnt[TOP] ^ pre_q.cnt[TOP-1];

endmodule

// File: rtl/vclk_slow.sv
module vclk_slow #(
    parameter int unsigned RATIO = 10,
    parameter int unsigned HIGH  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic lvl,
    output logic en
);

    localparam int unsigned W = $clog2(RATIO);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         lvl;
        logic         en;
    } slow_t;

    slow_t slow_d, slow_q;

    always_comb begin
        slow_d    = slow_q;
        slow_d.en = 1'b0;
        if (step) begin
            if (slow_q.cnt == W'(RATIO - 1)) begin
                slow_d.cnt = '0;
                slow_d.en  = 1'b1;
            end else begin
                slow_d.cnt = slow_q.cnt + 1'b1;
            end
        end
        slow_d.lvl = (slow_d.cnt < W'(HIGH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_q <= '{cnt: '0, lvl: 1'b1, en: 1'b0};
        end else begin
            slow_q <= slow_d;
        end
    end

    assign lvl = slow_q.lvl;
    assign en  = slow_q.en;

endmodule

// File: rtl/vclk_divider.sv
module vclk_divider
    import vclk_pkg::*;
#(
    parameter int unsigned STAGES  = DEF_STAGES,
    parameter int unsigned E_RATIO = DEF_E_RATIO,
    parameter int unsigned E_HIGH  = DEF_E_HIGH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk_en_n,
    input  logic ext_tick,
    output logic dot_clk,
    output logic dot_en,
    output logic cpu_clk,
    output logic cpu_en,
    output logic cck_clk,
    output logic cck_en,
    output logic cck_ph,
    output logic e_clk,
    output logic e_en
);

    localparam int unsigned DOT_IDX = 0;
    localparam int unsigned CPU_IDX = 1;
    localparam int unsigned CCK_IDX = STAGES - 1;

    logic              mtick;
    logic              period_last;
    logic              cpu_step;
    logic [STAGES-1:0] lvl;
    logic [STAGES-1:0] en;

    vclk_src_sel i_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_sel_n  (ext_clk_en_n),
        .ext_tick   (ext_tick),
        .period_last(period_last),
        .mtick      (mtick)
    );

    vclk_prescale #(
        .STAGES  (STAGES),
        .STEP_IDX(CPU_IDX)
    ) i_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (mtick),
        .lvl  (lvl),
        .en   (en),
        .step (cpu_step),
        .last (period_last),
        .ph   (cck_ph)
    );

    vclk_slow #(
        .RATIO(E_RATIO),
        .HIGH (E_HIGH)
    ) i_slow (
        .clk  (clk),
        .rst_n(rst_n),
        .step (cpu_step),
        .lvl  (e_clk),
        .en   (e_en)
    );

    assign dot_clk = lvl[DOT_IDX];
    assign dot_en  = en[DOT_IDX];
    assign cpu_clk = lvl[CPU_IDX];
    assign cpu_en  = en[CPU_IDX];
    assign cck_clk = lvl[CCK_IDX];
    assign cck_en  = en[CCK_IDX];

endmodule

// File: rtl/vclk_divider_chk.sv
module vclk_divider_chk (
    input logic clk,
    input logic rst_n,
    input logic dot_clk,
    input logic dot_en,
    input logic cpu_clk,
    input logic cpu_en,
    input logic cck_clk,
    input logic cck_en,
    input logic cck_ph,
    input logic e_clk,
    input logic e_en
);

    assert_cck_nested_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cck_en |-> (cpu_en && dot_en));

    assert_cpu_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> (cpu_clk && !$past(cpu_clk)));

    assert_e_with_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
        e_en |-> cpu_en);

    assert_e_rise_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_clk) |-> e_en);

    assert_phase_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cck_ph) |-> (cck_clk && !cpu_clk));

    assert_dot_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dot_en |=> !dot_en);

    assert_cck_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cck_en |=> !cck_en);

endmodule

bind vclk_divider vclk_divider_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .dot_clk(dot_clk),
    .dot_en (dot_en),
    .cpu_clk(cpu_clk),
    .cpu_en (cpu_en),
    .cck_clk(cck_clk),
    .cck_en (cck_en),
    .cck_ph (cck_ph),
    .e_clk  (e_clk),
    .e_en   (e_en)
);

// File: tb/test_vclk_divider.sv
module test_vclk_divider;

    localparam time CLK_P = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_clk_en_n = 1'b1;
    logic ext_tick = 1'b0;
    logic dot_clk, dot_en, cpu_clk, cpu_en, cck_clk, cck_en, cck_ph, e_clk, e_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // bench model: ticks since reset (mod 40), source, and tick on last edge
    int   t_m = 0;
    logic src_m = 1'b0;
    logic tk_m = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    vclk_divider i_vclk_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_en_n(ext_clk_en_n),
        .ext_tick    (ext_tick),
        .dot_clk     (dot_clk),
        .dot_en      (dot_en),
        .cpu_clk     (cpu_clk),
        .cpu_en      (cpu_en),
        .cck_clk     (cck_clk),
        .cck_en      (cck_en),
        .cck_ph      (cck_ph),
        .e_clk       (e_clk),
        .e_en        (e_en)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (T=%0d)", tag, what, act, exp, t_m);
        end
    endtask

    task automatic check_all();
        chk("R2", "dot_clk", dot_clk, (t_m % 2) == 0);
        chk("R2", "dot_en",  dot_en,  tk_m && (t_m % 2) == 0);
        chk("R3", "cpu_clk", cpu_clk, (t_m % 4) < 2);
        chk("R3", "cpu_en",  cpu_en,  tk_m && (t_m % 4) == 0);
        chk("R4", "cck_clk", cck_clk, (t_m % 8) < 4);
        chk("R4", "cck_en",  cck_en,  tk_m && (t_m % 8) == 0);
        chk("R5", "cck_ph",  cck_ph,  (t_m % 8) >= 2 && (t_m % 8) <= 5);
        chk("R6", "e_clk",   e_clk,   t_m < 16);
        chk("R6", "e_en",    e_en,    tk_m && t_m == 0);
    endtask

    // drive at the falling edge, model after the rising edge, compare at next fall
    task automatic step(input logic sel_n, input logic tk);
        logic mt;
        ext_clk_en_n = sel_n;
        ext_tick     = tk;
        @(posedge clk);
        mt   = src_m ? tk : 1'b1;
        tk_m = mt;
        if (mt) begin
            if ((t_m % 8) == 7) src_m = ~sel_n;
            t_m = (t_m + 1) % 40;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic t_reset();
        @(negedge clk);
        @(negedge clk);
        chk("R1", "dot_clk", dot_clk, 1);
        chk("R1", "cpu_clk", cpu_clk, 1);
        chk("R1", "cck_clk", cck_clk, 1);
        chk("R1", "e_clk",   e_clk,   1);
        chk("R1", "cck_ph",  cck_ph,  0);
        chk("R1", "pulses",  {dot_en, cpu_en, cck_en, e_en}, 0);
        rst_n = 1'b1;
        chk("R1", "release", {dot_en, cpu_en, cck_en, e_en}, 0);
    endtask

    // R2 R3 R4 R5 R6 R9: free run on the internal clock, over three slow periods
    task automatic t_internal();
        for (int i = 0; i < 125; i++) step(1'b1, 1'b0);
    endtask

    // R7: hand over to the external source, then stall it and tick it sparsely
    task automatic t_ext_stall();
        logic [3:0] snap;
        for (int i = 0; i < 10 && !src_m; i++) step(1'b0, 1'b0);
        chk("R7", "source taken", src_m, 1);
        snap = {dot_clk, cpu_clk, cck_clk, e_clk};
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b0);
            chk("R7", "levels held", {dot_clk, cpu_clk, cck_clk, e_clk}, snap);
            chk("R7", "no pulse", {dot_en, cpu_en, cck_en, e_en}, 0);
        end
        for (int i = 0; i < 130; i++) step(1'b0, (i % 3) == 0);
    endtask

    // R8: source changes wait for the colour period to close, in both directions
    task automatic t_switch();
        logic [2:0] snap;
        int toggles;
        logic prev;
        for (int i = 0; i < 8 && (t_m % 8) != 3; i++) step(1'b0, 1'b1);
        snap = {dot_clk, cpu_clk, cck_clk};
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0);
            chk("R8", "old ext source still holds", {dot_clk, cpu_clk, cck_clk}, snap);
        end
        for (int i = 0; i < 8 && src_m; i++) step(1'b1, 1'b1);
        chk("R8", "internal resumed", src_m, 0);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 8 && (t_m % 8) != 3; i++) step(1'b1, 1'b0);
        toggles = 0;
        prev = dot_clk;
        for (int i = 0; i < 10; i++) begin
            step(1'b0, 1'b0);
            if (dot_clk != prev) toggles++;
            prev = dot_clk;
        end
        chk("R8", "ticks run out to boundary", toggles, 5);
        chk("R8", "stopped at boundary", cck_en, 0);
        chk("R8", "colour level at boundary", cck_clk, 1);
    endtask

    initial begin
        t_reset();
        t_internal();
        t_ext_stall();
        t_switch();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule